// File: doc/BRIEF.md
# Vector Source Operand Expander

This block conditions one wide source operand on its way into a vector ALU. In a single registered stage it rearranges the 64-bit halves of the operand or widens the elements of one half to twice their width. It then permutes the operand's four 32-bit components and, for floating-point operations, applies absolute-value and negate modifiers to the sign bit of every element.

The element width is chosen per operation with a 2-bit code: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. When widening, each output lane of that width is built from a narrow element of half that width, taken from the selected 64-bit half. The 2-bit modifier field has two meanings. For integer operations it selects how a narrow element becomes a wide one. For float operations it carries the abs and neg flags.

Register file reads and operand forwarding happen upstream and are not part of this block.

Top module: `vec_src_expander`

## Requirements
- R1: A synchronous active-high reset clears `res_vld` and `res_opnd` to zero.
- R2: `res_opnd` and `res_vld` are registered one cycle after `src_vld`. While `src_vld` is low, `res_opnd` holds its value and `res_vld` drops.
- R3: The routing code `xmode` works as follows before the component select:
  - 0 passes the operand unchanged.
  - 1 copies bits [63:0] into both halves.
  - 2 copies bits [127:64] into both halves.
  - 3 exchanges the two halves.
- R4: Routing codes 4 and 5 widen bits [63:0] and bits [127:64] respectively. With element width E = 8<<`ewidth`, output lane i (bits [i*E +: E]) is made from narrow element i (bits [i*E/2 +: E/2]) of that half, for every i below 128/E.
- R5: For integer operations (`is_flt`=0), `mod` selects the widening method:
  - 0 sign-extends.
  - 1 zero-extends.
  - 2 places the narrow element in both halves of the lane.
  - 3 places it in the upper half and fills the lower half with zeros.
- R6: Routing codes 6 and 7 widen as codes 4 and 5 do, then exchange the two 64-bit halves of the widened result.
- R7: For integer operations, `mod` has no effect under routing codes 0 to 3. For float operations, widening always sign-extends.
- R8: The component select `swz` has four 2-bit fields. Output 32-bit component k is component `swz[2k+1:2k]` of the routed value, so 8'hE4 is the identity.
- R9: For float operations, `mod` bit 0 clears the most significant bit of every E-bit lane and `mod` bit 1 then inverts it. This is applied after widening and the component select, under every routing code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_vld | input | 1 | Operand and controls are valid this cycle |
| src_opnd | input | 128 | Raw register operand |
| xmode | input | 3 | Routing / widening code |
| mod | input | 2 | Extension method (integer) or abs/neg flags (float) |
| ewidth | input | 2 | Element width code |
| is_flt | input | 1 | Operation is floating point |
| swz | input | 8 | Component select, four 2-bit fields |
| res_vld | output | 1 | Result valid |
| res_opnd | output | 128 | Conditioned operand |

## Verification
Several properties are checked on every cycle:
- The one-cycle valid latency and the hold of the result when no operand arrives.
- The plain pass, duplicate and exchange routings under the identity component select.
- The zero fill of the low byte for shift-widened 16-bit lanes.
- The forced sign bit of 32-bit float lanes when both abs and neg are set.

The directed scenarios cover the cases that need a computed expectation:
- The lane mapping for every element width and both halves.
- The four extension methods, and the exchange after widening.
- Non-identity component selects.
- The interaction of the float flags with widening.
- The checks that `mod` is inert where it should be.

// File: rtl/vse_pkg.sv
package vse_pkg;

  typedef enum logic [2:0] {
    XM_PASS      = 3'd0,
    XM_DUP_LO    = 3'd1,
    XM_DUP_HI    = 3'd2,
    XM_XCHG      = 3'd3,
    XM_WID_LO    = 3'd4,
    XM_WID_HI    = 3'd5,
    XM_WID_LO_X  = 3'd6,
    XM_WID_HI_X  = 3'd7
  } xmode_e;

  typedef enum logic [1:0] {
    EXT_SIGN = 2'd0,
    EXT_ZERO = 2'd1,
    EXT_DUP  = 2'd2,
    EXT_SHL  = 2'd3
  } ext_e;

  localparam int unsigned NUM_WIDTHS = 4;
  localparam int unsigned NUM_COMPS  = 4;
  localparam logic [7:0]  SWZ_IDENT  = 8'hE4;

endpackage

// File: rtl/vse_widen.sv
module vse_widen
  import vse_pkg::*;
#(
  parameter int unsigned OPND_W = 128
) (
  input  logic [OPND_W/2-1:0] half_i,
  input  logic [1:0]          width_i,
  input  ext_e                ext_i,
  output logic [OPND_W-1:0]   wide_o
);
  logic [OPND_W-1:0] cand [NUM_WIDTHS];

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int unsigned E = 8 << g;
    localparam int unsigned N = E / 2;
    localparam int unsigned L = OPND_W / E;
    for (genvar i = 0; i < L; i++) begin : g_lane
      logic [N-1:0] nb;
      assign nb = half_i[i*N +: N];
      always_comb begin
        unique case (ext_i)
          EXT_SIGN: cand[g][i*E +: E] = {{N{nb[N-1]}}, nb};
          EXT_ZERO: cand[g][i*E +: E] = {{N{1'b0}}, nb};
          EXT_DUP:  cand[g][i*E +: E] = {nb, nb};
          default:  cand[g][i*E +: E] = {nb, {N{1'b0}}};
        endcase
      end
    end
  end

  assign wide_o = cand[width_i];
endmodule

// File: rtl/vse_route.sv
module vse_route
  import vse_pkg::*;
#(
  parameter int unsigned OPND_W = 128
) (
  input  logic [OPND_W-1:0] opnd_i,
  input  xmode_e            xmode_i,
  input  ext_e              ext_i,
  input  logic [1:0]        width_i,
  output logic [OPND_W-1:0] routed_o
);
  localparam int unsigned HALF_W = OPND_W / 2;

  logic [HALF_W-1:0] lo, hi, pick;
  logic [OPND_W-1:0] wide;

  assign lo   = opnd_i[HALF_W-1:0];
  assign hi   = opnd_i[OPND_W-1:HALF_W];
  assign pick = xmode_i[0] ? hi : lo;

  vse_widen #(.OPND_W(OPND_W)) i_widen (
    .half_i (pick),
    .width_i(width_i),
    .ext_i  (ext_i),
    .wide_o (wide)
  );

  always_comb begin
    unique case (xmode_i)
      XM_PASS:   routed_o = opnd_i;
      XM_DUP_LO: routed_o = {lo, lo};
      XM_DUP_HI: routed_o = {hi, hi};
      XM_XCHG:   routed_o = {lo, hi};
      XM_WID_LO, XM_WID_HI:
                 routed_o = wide;
      default:   routed_o = {wide[HALF_W-1:0], wide[OPND_W-1:HALF_W]};
    endcase
  end
endmodule

// File: rtl/vse_swz.sv
module vse_swz
  import vse_pkg::*;
#(
  parameter int unsigned OPND_W = 128
) (
  input  logic [OPND_W-1:0] data_i,
  input  logic [7:0]        sel_i,
  output logic [OPND_W-1:0] data_o
);
  localparam int unsigned COMP_W = OPND_W / NUM_COMPS;

  logic [COMP_W-1:0] comp [NUM_COMPS];

  for (genvar k = 0; k < NUM_COMPS; k++) begin : g_comp
    assign comp[k]                = data_i[k*COMP_W +: COMP_W];
    assign data_o[k*COMP_W +: COMP_W] = comp[sel_i[2*k +: 2]];
  end
endmodule

// File: rtl/vse_fsign.sv
module vse_fsign
  import vse_pkg::*;
#(
  parameter int unsigned OPND_W = 128
) (
  input  logic [OPND_W-1:0] data_i,
  input  logic [1:0]        width_i,
  input  logic              abs_i,
  input  logic              neg_i,
  output logic [OPND_W-1:0] data_o
);
  logic [OPND_W-1:0] cand [NUM_WIDTHS];

  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int unsigned E = 8 << g;
    localparam int unsigned L = OPND_W / E;
    for (genvar j = 0; j < L; j++) begin : g_lane
      assign cand[g][j*E +: E] =
        {(data_i[j*E+E-1] & ~abs_i) ^ neg_i, data_i[j*E +: E-1]};
    end
  end

  assign data_o = cand[width_i];
endmodule

// File: rtl/vec_src_expander.sv
module vec_src_expander
  import vse_pkg::*;
#(
  parameter int unsigned OPND_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_vld,
  input  logic [OPND_W-1:0] src_opnd,
  input  logic [2:0]        xmode,
  input  logic [1:0]        mod,
  input  logic [1:0]        ewidth,
  input  logic              is_flt,
  input  logic [7:0]        swz,
  output logic              res_vld,
  output logic [OPND_W-1:0] res_opnd
);
  localparam int unsigned HALF_W = OPND_W / 2;
  localparam int unsigned L32    = OPND_W / 32;
  localparam int unsigned L16    = OPND_W / 16;

  ext_e              ext_sel;
  logic [OPND_W-1:0] routed, swizzled, signed_d;

  // float operations always sign-extend when widening
  assign ext_sel = is_flt ? EXT_SIGN : ext_e'(mod);

  vse_route #(.OPND_W(OPND_W)) i_route (
    .opnd_i  (src_opnd),
    .xmode_i (xmode_e'(xmode)),
    .ext_i   (ext_sel),
    .width_i (ewidth),
    .routed_o(routed)
  );

  vse_swz #(.OPND_W(OPND_W)) i_swz (
    .data_i(routed),
    .sel_i (swz),
    .data_o(swizzled)
  );

  vse_fsign #(.OPND_W(OPND_W)) i_fsign (
    .data_i (swizzled),
    .width_i(ewidth),
    .abs_i  (is_flt & mod[0]),
    .neg_i  (is_flt & mod[1]),
    .data_o (signed_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld  <= 1'b0;
      res_opnd <= '0;
    end else begin
      res_vld <= src_vld;
      if (src_vld) res_opnd <= signed_d;
    end
  end

  // ---------------- assertions ----------------
  logic [L32-1:0] msb32;
  logic [L16-1:0] lowbyte_nz;
  for (genvar j = 0; j < L32; j++) begin : g_msb32
    assign msb32[j] = res_opnd[32*j+31];
  end
  for (genvar j = 0; j < L16; j++) begin : g_lb16
    assign lowbyte_nz[j] = |res_opnd[16*j +: 8];
  end

  logic plain_int;
  assign plain_int = src_vld && !is_flt && swz == SWZ_IDENT;

  AST_VLD_RISE: assert property (@(posedge clk) disable iff (rst)
    src_vld |=> res_vld); // R2
  AST_VLD_DROP: assert property (@(posedge clk) disable iff (rst)
    !src_vld |=> !res_vld); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !src_vld |=> $stable(res_opnd)); // R2
  AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
    plain_int && xmode == 3'd0 |=> res_opnd == $past(src_opnd)); // R3
  AST_DUP_LO: assert property (@(posedge clk) disable iff (rst)
    plain_int && xmode == 3'd1 |=>
      res_opnd == {$past(src_opnd[HALF_W-1:0]), $past(src_opnd[HALF_W-1:0])}); // R3
  AST_XCHG: assert property (@(posedge clk) disable iff (rst)
    plain_int && xmode == 3'd3 |=>
      res_opnd == {$past(src_opnd[HALF_W-1:0]), $past(src_opnd[OPND_W-1:HALF_W])}); // R3
  AST_SHL_ZERO_LOW: assert property (@(posedge clk) disable iff (rst)
    src_vld && !is_flt && xmode[2] && mod == 2'd3 && ewidth == 2'd1 |=>
      lowbyte_nz == '0); // R5
  AST_FLT_SIGN_SET: assert property (@(posedge clk) disable iff (rst)
    src_vld && is_flt && mod == 2'd3 && ewidth == 2'd2 |=> &msb32); // R9
endmodule

// File: tb/test_vec_src_expander.sv
module test_vec_src_expander;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic         src_vld;
  logic [127:0] src_opnd;
  logic [2:0]   xmode;
  logic [1:0]   mod;
  logic [1:0]   ewidth;
  logic         is_flt;
  logic [7:0]   swz;
  logic         res_vld;
  logic [127:0] res_opnd;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_src_expander i_vec_src_expander (
    .clk(clk), .rst(rst), .src_vld(src_vld), .src_opnd(src_opnd),
    .xmode(xmode), .mod(mod), .ewidth(ewidth), .is_flt(is_flt), .swz(swz),
    .res_vld(res_vld), .res_opnd(res_opnd)
  );

  // expected value computed from the requirements
  function automatic logic [127:0] model(input logic [127:0] v, input logic [2:0] xm,
      input logic [1:0] md, input logic [1:0] w, input logic fl, input logic [7:0] sw);
    logic [127:0] r, s, h, nb, nmask, lmask, wide;
    int e, n, l;
    e = 8 << w; n = e / 2; l = 128 / e;
    nmask = (128'd1 << n) - 1;
    lmask = (128'd1 << e) - 1;
    case (xm)
      3'd0: r = v;
      3'd1: r = {v[63:0], v[63:0]};
      3'd2: r = {v[127:64], v[127:64]};
      3'd3: r = {v[63:0], v[127:64]};
      default: begin
        h = xm[0] ? {64'd0, v[127:64]} : {64'd0, v[63:0]};
        r = '0;
        for (int i = 0; i < l; i++) begin
          nb = (h >> (i*n)) & nmask;
          case (fl ? 2'd0 : md)
            2'd0: wide = nb | (nb[n-1] ? (lmask & ~nmask) : 128'd0);
            2'd1: wide = nb;
            2'd2: wide = nb | (nb << n);
            default: wide = nb << n;
          endcase
          r = r | (wide << (i*e));
        end
        if (xm[1]) r = {r[63:0], r[127:64]};
      end
    endcase
    for (int k = 0; k < 4; k++) s[32*k +: 32] = r[32*sw[2*k +: 2] +: 32];
    if (fl) begin
      for (int j = 0; j < l; j++) begin
        if (md[0]) s[j*e+e-1] = 1'b0;
        if (md[1]) s[j*e+e-1] = ~s[j*e+e-1];
      end
    end
    return s;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one operand at a falling edge, sample one cycle later
  task automatic apply(input string req, input logic [127:0] v, input logic [2:0] xm,
      input logic [1:0] md, input logic [1:0] w, input logic fl, input logic [7:0] sw);
    @(negedge clk);
    src_vld = 1'b1; src_opnd = v; xmode = xm; mod = md; ewidth = w; is_flt = fl; swz = sw;
    @(negedge clk);
    src_vld = 1'b0;
    check({req, " valid"}, {127'd0, res_vld}, 128'd1);
    check(req, res_opnd, model(v, xm, md, w, fl, sw));
  endtask

  localparam logic [127:0] PAT_A = 128'hFEDCBA98_76543210_8001_7FFF_80FF_0102;
  localparam logic [127:0] PAT_B = 128'h89ABCDEF_01234567_F00D_8421_C3A5_5A3C;

  task automatic t_reset();
    rst = 1'b1; src_vld = 1'b0; src_opnd = '0; xmode = '0; mod = '0;
    ewidth = '0; is_flt = 1'b0; swz = 8'hE4;
    repeat (3) @(negedge clk);
    check("R1 res_vld", {127'd0, res_vld}, 128'd0);
    check("R1 res_opnd", res_opnd, 128'd0);
    rst = 1'b0;
  endtask

  task automatic t_routing();
    for (int m = 0; m < 4; m++) apply("R3 routing", PAT_A, 3'(m), 2'd0, 2'd2, 1'b0, 8'hE4);
    apply("R3 dup hi literal", PAT_B, 3'd2, 2'd0, 2'd2, 1'b0, 8'hE4);
    check("R3 dup hi literal", res_opnd, {PAT_B[127:64], PAT_B[127:64]});
  endtask

  task automatic t_widen();
    for (int w = 0; w < 4; w++) begin
      apply("R4 widen lo", PAT_A, 3'd4, 2'd0, 2'(w), 1'b0, 8'hE4);
      apply("R4 widen hi", PAT_B, 3'd5, 2'd1, 2'(w), 1'b0, 8'hE4);
    end
    // 0x8001 sign-extends into the 32-bit lane 3
    apply("R5 sign literal", PAT_A, 3'd4, 2'd0, 2'd2, 1'b0, 8'hE4);
    check("R5 sign literal", {96'd0, res_opnd[127:96]}, 128'hFFFF8001);
    for (int md = 0; md < 4; md++) begin
      apply("R5 ext method", PAT_A, 3'd4, 2'(md), 2'd2, 1'b0, 8'hE4);
      apply("R5 ext method 16", PAT_B, 3'd5, 2'(md), 2'd1, 1'b0, 8'hE4);
    end
    apply("R5 shl literal", PAT_A, 3'd4, 2'd3, 2'd2, 1'b0, 8'hE4);
    check("R5 shl literal", {96'd0, res_opnd[31:0]}, 128'h01020000);
  endtask

  task automatic t_widen_xchg();
    apply("R6 widen lo xchg", PAT_A, 3'd6, 2'd0, 2'd2, 1'b0, 8'hE4);
    check("R6 lane0 in upper half", {96'd0, res_opnd[95:64]}, 128'h00000102);
    apply("R6 widen hi xchg", PAT_B, 3'd7, 2'd2, 2'd1, 1'b0, 8'hE4);
    apply("R6 widen hi xchg 64", PAT_A, 3'd7, 2'd3, 2'd3, 1'b0, 8'hE4);
  endtask

  task automatic t_mod_inert();
    for (int md = 0; md < 4; md++) begin
      apply("R7 mod inert xchg", PAT_B, 3'd3, 2'(md), 2'd1, 1'b0, 8'hE4);
      check("R7 mod inert xchg", res_opnd, {PAT_B[63:0], PAT_B[127:64]});
    end
    apply("R7 float widen sign-ext", PAT_A, 3'd4, 2'd0, 2'd2, 1'b1, 8'hE4);
    check("R7 float widen sign-ext", {96'd0, res_opnd[127:96]}, 128'hFFFF8001);
  endtask

  task automatic t_swizzle();
    apply("R8 reverse", PAT_A, 3'd0, 2'd0, 2'd2, 1'b0, 8'h1B);
    check("R8 reverse", res_opnd, {PAT_A[31:0], PAT_A[63:32], PAT_A[95:64], PAT_A[127:96]});
    apply("R8 broadcast", PAT_B, 3'd0, 2'd0, 2'd0, 1'b0, 8'hFF);
    apply("R8 after widen", PAT_A, 3'd5, 2'd1, 2'd2, 1'b0, 8'h4E);
  endtask

  task automatic t_float();
    for (int md = 0; md < 4; md++) begin
      apply("R9 float pass", PAT_A, 3'd0, 2'(md), 2'd1, 1'b1, 8'hE4);
      apply("R9 float widened", PAT_B, 3'd6, 2'(md), 2'd2, 1'b1, 8'h9C);
    end
    apply("R9 abs literal", 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 3'd0, 2'd1, 2'd3, 1'b1, 8'hE4);
    check("R9 abs literal", res_opnd, 128'h7FFFFFFF_FFFFFFFF_7FFFFFFF_FFFFFFFF);
  endtask

  task automatic t_hold();
    logic [127:0] prev;
    apply("R2 load", PAT_B, 3'd0, 2'd0, 2'd2, 1'b0, 8'hE4);
    prev = res_opnd;
    @(negedge clk);
    src_opnd = ~PAT_B;
    @(negedge clk);
    check("R2 idle drops valid", {127'd0, res_vld}, 128'd0);
    check("R2 idle holds data", res_opnd, prev);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_routing();
    t_widen();
    t_widen_xchg();
    t_mod_inert();
    t_swizzle();
    t_float();
    t_hold();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule